// File: doc/BRIEF.md
# Binary64 overflow and underflow result selector

This block sits at the end of a double-precision add, multiply or fused multiply-add datapath. It takes over the result when the exponent logic upstream has decided that the true value cannot be represented. In that case it picks the special 64-bit result the rounding mode calls for and the status flags that go with it. When the value fits, the normally rounded result from the upstream rounder goes through unchanged on a bypass path.

The choice has four possible outcomes:
- Overflow gives either infinity or the largest finite value.
- A tiny result gives either zero or the smallest denormal.

In both cases the choice follows the rounding mode and the result sign. Every such case also raises the inexact flag. The caller ORs the returned flag vector into its sticky status register.

The logic is purely combinational. A parameter can add one output register stage.

Top module: `ovfuf_result_sel`

## Requirements
- R1: `in_mode` encodes 0 = nearest-even, 1 = toward zero, 2 = toward plus infinity and 3 = toward minus infinity. A positive overflow yields 0x7FF0000000000000 (+infinity) under modes 0 and 2. It yields 0x7FEFFFFFFFFFFFFF (largest finite value) under modes 1 and 3.
- R2: A negative overflow yields 0xFFF0000000000000 under modes 0 and 3. It yields 0xFFEFFFFFFFFFFFFF under modes 1 and 2.
- R3: The flag bits in `out_flags` are invalid [4], divide-by-zero [3], overflow [2], underflow [1] and inexact [0]. Every overflow returns flags 5'b00101 in all modes.
- R4: A positive tiny result yields +0 (0x0000000000000000) under modes 1 and 3. It yields 0x0000000000000001 under mode 2. Under mode 0 it yields 0x0000000000000001 when `in_rnd_up` is 1 and +0 otherwise.
- R5: A negative tiny result yields 0x8000000000000001 under mode 3 and -0 (0x8000000000000000) under modes 1 and 2. Under mode 0 it yields 0x8000000000000001 when `in_rnd_up` is 1 and -0 otherwise.
- R6: Every tiny result returns flags 5'b00011 in all modes.
- R7: When `in_ovf` and `in_tiny` are both 1, the overflow rule wins for both the value and the flags.
- R8: When neither indicator is set, `out_result` equals `in_result` and `out_flags` equals {4'b0000, `in_inexact`}. An exact denormal from a subtraction therefore comes out unchanged with no flag raised.
- R9: `in_rnd_up` has no effect on the result under modes 1, 2 and 3, and no effect when the tiny indicator is clear.
- R10: With REG_OUT = 1, both outputs appear one clock after their inputs, and during reset they read zero. With REG_OUT = 0, they follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| in_sign | input | 1 | Sign of the exact result |
| in_ovf | input | 1 | Exponent overflowed |
| in_tiny | input | 1 | Result is tiny and inexact below the smallest denormal |
| in_mode | input | 2 | Rounding mode |
| in_rnd_up | input | 1 | Round-up decision for a tiny result under nearest-even |
| in_result | input | 64 | Normally rounded result on the bypass path |
| in_inexact | input | 1 | Inexact indication of the bypass result |
| out_result | output | 64 | Selected result |
| out_flags | output | 5 | Flags {invalid, div-by-zero, overflow, underflow, inexact} |

## Verification
The bench builds the block twice at the default binary64 widths: once with REG_OUT = 1 and once with REG_OUT = 0. This covers both the registered timing and the same-cycle timing. Each build receives every combination of sign, overflow, tiny, rounding mode, round-up and inexact, with a different bypass pattern each time. This reaches every special value, the precedence case where both indicators are set, and the cases where the round-up input is ignored. An exact-denormal pass-through and the reset value of the registered outputs complete the coverage.

// File: rtl/ovfuf_pkg.sv
package ovfuf_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  localparam int FLAG_W = 5;
  localparam int FL_NX  = 0;
  localparam int FL_UF  = 1;
  localparam int FL_OF  = 2;
  localparam int FL_DZ  = 3;
  localparam int FL_NV  = 4;

  // 1 when an overflow must saturate to the largest finite value
  function automatic logic ovf_saturates(input logic [1:0] mode, input logic sgn);
    logic r;
    case (mode)
      RM_NEAR: r = 1'b0;
      RM_ZERO: r = 1'b1;
      RM_UP:   r = sgn;
      default: r = ~sgn;
    endcase
    return r;
  endfunction

  // 1 when a tiny result must become the smallest denormal
  function automatic logic tiny_rounds_out(input logic [1:0] mode, input logic sgn,
                                           input logic rnd_up);
    logic r;
    case (mode)
      RM_NEAR: r = rnd_up;
      RM_ZERO: r = 1'b0;
      RM_UP:   r = ~sgn;
      default: r = sgn;
    endcase
    return r;
  endfunction

  function automatic logic [FLAG_W-1:0] flag_word(input logic nv, input logic dz,
                                                   input logic of, input logic uf,
                                                   input logic nx);
    logic [FLAG_W-1:0] f;
    f        = '0;
    f[FL_NV] = nv;
    f[FL_DZ] = dz;
    f[FL_OF] = of;
    f[FL_UF] = uf;
    f[FL_NX] = nx;
    return f;
  endfunction

endpackage

// File: rtl/ovfuf_ovf_pick.sv
module ovfuf_ovf_pick #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         sgn,
  input  logic [1:0]   mode,
  output logic         pick_max,
  output logic [W-1:0] value
);
  import ovfuf_pkg::*;

  logic [W-1:0] inf_val;
  logic [W-1:0] max_val;

  assign pick_max = ovf_saturates(mode, sgn);
  assign inf_val  = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  assign max_val  = {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
  assign value    = pick_max ? max_val : inf_val;
endmodule

// File: rtl/ovfuf_tiny_pick.sv
module ovfuf_tiny_pick #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         sgn,
  input  logic [1:0]   mode,
  input  logic         rnd_up,
  output logic         pick_min,
  output logic [W-1:0] value
);
  import ovfuf_pkg::*;

  assign pick_min = tiny_rounds_out(mode, sgn, rnd_up);
  assign value    = {sgn, {(EXP_W+FRAC_W-1){1'b0}}, pick_min};
endmodule

// File: rtl/ovfuf_out_stage.sv
module ovfuf_out_stage #(
  parameter int W       = 64,
  parameter int F       = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_res,
  input  logic [F-1:0] d_flg,
  output logic [W-1:0] q_res,
  output logic [F-1:0] q_flg
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_res <= '0;
          q_flg <= '0;
        end else begin
          q_res <= d_res;
          q_flg <= d_flg;
        end
      end
    end else begin : g_wire
      assign q_res = d_res;
      assign q_flg = d_flg;
    end
  endgenerate
endmodule

// File: rtl/ovfuf_result_sel.sv
module ovfuf_result_sel #(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter bit REG_OUT = 1'b1,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int F      = ovfuf_pkg::FLAG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_sign,
  input  logic         in_ovf,
  input  logic         in_tiny,
  input  logic [1:0]   in_mode,
  input  logic         in_rnd_up,
  input  logic [W-1:0] in_result,
  input  logic         in_inexact,
  output logic [W-1:0] out_result,
  output logic [F-1:0] out_flags
);
  import ovfuf_pkg::*;

  // named events for the checker
  logic         ovf_evt;
  logic         tiny_evt;
  logic         byp_evt;
  logic         pick_max;
  logic         pick_min;
  logic [W-1:0] ovf_val;
  logic [W-1:0] tiny_val;
  logic [W-1:0] sel_result;
  logic [F-1:0] sel_flags;

  assign ovf_evt  = in_ovf;
  assign tiny_evt = in_tiny & ~in_ovf;
  assign byp_evt  = ~in_ovf & ~in_tiny;

  ovfuf_ovf_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ovf (
    .sgn(in_sign), .mode(in_mode), .pick_max(pick_max), .value(ovf_val)
  );

  ovfuf_tiny_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_tiny (
    .sgn(in_sign), .mode(in_mode), .rnd_up(in_rnd_up),
    .pick_min(pick_min), .value(tiny_val)
  );

  always_comb begin
    if (ovf_evt) begin
      sel_result = ovf_val;
      sel_flags  = flag_word(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    end else if (tiny_evt) begin
      sel_result = tiny_val;
      sel_flags  = flag_word(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    end else begin
      sel_result = in_result;
      sel_flags  = flag_word(1'b0, 1'b0, 1'b0, 1'b0, in_inexact);
    end
  end

  ovfuf_out_stage #(.W(W), .F(F), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .d_res(sel_result), .d_flg(sel_flags),
    .q_res(out_result), .q_flg(out_flags)
  );
endmodule

// File: rtl/ovfuf_chk.sv
module ovfuf_chk #(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter bit REG_OUT = 1'b1,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_sign,
  input logic         in_ovf,
  input logic         in_tiny,
  input logic [1:0]   in_mode,
  input logic         in_rnd_up,
  input logic [W-1:0] in_result,
  input logic         in_inexact,
  input logic         ovf_evt,
  input logic         tiny_evt,
  input logic         byp_evt,
  input logic [W-1:0] sel_result,
  input logic [4:0]   sel_flags,
  input logic [W-1:0] out_result,
  input logic [4:0]   out_flags
);
  localparam logic [W-1:0] P_INF = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] P_MAX = {1'b0, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
  localparam logic [W-1:0] SBIT  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};

  a_r1_pos_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !in_sign |-> sel_result == (in_mode[0] ? P_MAX : P_INF));

  a_r2_neg_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && in_sign |-> sel_result == (SBIT | ((in_mode == 2'd1 || in_mode == 2'd2) ? P_MAX : P_INF)));

  a_r3_ovf_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> sel_flags == 5'b00101);

  a_r4_pos_tiny_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tiny_evt && !in_sign && in_mode != 2'd2 && !(in_mode == 2'd0 && in_rnd_up) |-> sel_result == '0);

  a_r5_neg_tiny_min: assert property (@(posedge clk) disable iff (!rst_n)
    tiny_evt && in_sign && in_mode == 2'd3 |-> sel_result == (SBIT | ONE));

  a_r6_tiny_flags: assert property (@(posedge clk) disable iff (!rst_n)
    tiny_evt |-> sel_flags == 5'b00011);

  a_r7_ovf_first: assert property (@(posedge clk) disable iff (!rst_n)
    in_ovf && in_tiny |-> sel_flags[2] && !sel_flags[1]);

  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    byp_evt |-> sel_result == in_result && sel_flags == {4'b0000, in_inexact});

  generate
    if (REG_OUT) begin : g_reg_chk
      a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_result == $past(sel_result) && out_flags == $past(sel_flags));
    end else begin : g_comb_chk
      a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        out_result == sel_result && out_flags == sel_flags);
    end
  endgenerate
endmodule

bind ovfuf_result_sel ovfuf_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_sign(in_sign), .in_ovf(in_ovf), .in_tiny(in_tiny),
  .in_mode(in_mode), .in_rnd_up(in_rnd_up), .in_result(in_result), .in_inexact(in_inexact),
  .ovf_evt(ovf_evt), .tiny_evt(tiny_evt), .byp_evt(byp_evt),
  .sel_result(sel_result), .sel_flags(sel_flags),
  .out_result(out_result), .out_flags(out_flags)
);

// File: tb/test_ovfuf_result_sel.sv
module test_ovfuf_result_sel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s, ov, ti, ru, nx;
  logic [1:0]  md;
  logic [63:0] res;
  logic [63:0] r_res, c_res;
  logic [4:0]  r_flg, c_flg;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovfuf_result_sel #(.REG_OUT(1'b1)) i_ovfuf_result_sel (
    .clk(clk), .rst_n(rst_n), .in_sign(s), .in_ovf(ov), .in_tiny(ti), .in_mode(md),
    .in_rnd_up(ru), .in_result(res), .in_inexact(nx), .out_result(r_res), .out_flags(r_flg)
  );

  ovfuf_result_sel #(.REG_OUT(1'b0)) i_ovfuf_result_sel_comb (
    .clk(clk), .rst_n(rst_n), .in_sign(s), .in_ovf(ov), .in_tiny(ti), .in_mode(md),
    .in_rnd_up(ru), .in_result(res), .in_inexact(nx), .out_result(c_res), .out_flags(c_flg)
  );

  task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s result act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk5(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s flags act=%b exp=%b", tag, act, exp);
    end
  endtask

  // expected value from the requirements
  function automatic logic [63:0] exp_res(input logic sg, input logic o, input logic t,
                                          input logic [1:0] m, input logic r, input logic [63:0] b);
    logic away;
    if (o) begin
      // rounds away from zero to infinity
      away = (m == 2'd0) || (m == 2'd2 && !sg) || (m == 2'd3 && sg);
      return {sg, 63'h0} + (away ? 64'h7FF0000000000000 : 64'h7FEFFFFFFFFFFFFF);
    end else if (t) begin
      away = (m == 2'd0 && r) || (m == 2'd2 && !sg) || (m == 2'd3 && sg);
      return {sg, 63'h0} + (away ? 64'd1 : 64'd0);
    end
    return b;
  endfunction

  function automatic logic [4:0] exp_flg(input logic o, input logic t, input logic x);
    if (o) return 5'b00101;
    if (t) return 5'b00011;
    return {4'b0000, x};
  endfunction

  function automatic string tag_of(input logic sg, input logic o, input logic t,
                                   input logic [1:0] m, input logic r, input bit flags);
    if (o && t) return "R7";
    if (o) return flags ? "R3" : (sg ? "R2" : "R1");
    if (t) begin
      if (flags) return "R6";
      if (r && m != 2'd0) return "R9";
      return sg ? "R5" : "R4";
    end
    if (r) return "R9";
    return "R8";
  endfunction

  initial begin
    s = 0; ov = 0; ti = 0; md = 0; ru = 0; nx = 0; res = 64'hDEAD_BEEF_0000_0001;
    repeat (3) @(posedge clk);
    #1;
    chk64("R10 reset", r_res, 64'h0);
    chk5("R10 reset", r_flg, 5'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 128; i++) begin
      logic [63:0] er;
      logic [4:0]  ef;
      @(negedge clk);
      s = i[0]; ov = i[1]; ti = i[2]; md = i[4:3]; ru = i[5]; nx = i[6];
      res = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
      er = exp_res(s, ov, ti, md, ru, res);
      ef = exp_flg(ov, ti, nx);
      #1;
      chk64(tag_of(s, ov, ti, md, ru, 0), c_res, er);
      chk5(tag_of(s, ov, ti, md, ru, 1), c_flg, ef);
      @(posedge clk);
      #1;
      chk64("R10 registered", r_res, er);
      chk5("R10 registered", r_flg, ef);
    end

    // exact denormal from a subtraction passes unflagged
    @(negedge clk);
    s = 0; ov = 0; ti = 0; md = 2'd2; ru = 0; nx = 0; res = 64'h0000_0000_0000_0001;
    #1;
    chk64("R8 exact denormal", c_res, 64'h1);
    chk5("R8 exact denormal", c_flg, 5'b0);
    @(posedge clk);
    #1;
    chk64("R8 exact denormal reg", r_res, 64'h1);
    chk5("R8 exact denormal reg", r_flg, 5'b0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule